// File: doc/BRIEF.md
# 1-Wire Link-Layer Bus Monitor

This block listens to one open-drain 1-Wire line and reports what happens on it at the link layer. It never drives the line. The line is brought into the system clock domain through a synchronizer chain. One timer then measures every low and high interval in clock cycles. From these intervals the block reports three kinds of event, each as a one-cycle strobe: a time slot with the bit value sampled in it, a reset pulse together with whether it qualified only as a short (overdrive) reset, and the presence sample taken after a reset together with whether a device answered.

A higher protocol layer drives the overdrive input once it has switched the bus to the fast timing set. The block registers that input and uses it to choose the short bit and presence sample points, and to enable the short reset threshold. All sample points and thresholds are parameters counted in clock cycles, so one netlist serves any clock rate. A build-time option removes overdrive support completely.

Top module: `owire_link_monitor`

## Requirements
- R1: During a synchronous reset, and in the cycle after it, all three strobes and their flags are low. The block then waits for a falling edge, with normal timing selected.
- R2: The line passes through SYNC_STAGES flops (default 2) before any decision is made. With the line driven low from a clock edge onward, the slot bit strobe is high in the window that starts SYNC_STAGES + bit threshold + 1 clock edges later.
- R3: A slot's bit is sampled when the cycle count since the fall was detected equals the bit threshold (NRM_BIT_CYC in normal mode, OVD_BIT_CYC in overdrive mode). The bit strobe carries the synchronized line level: 1 for high, 0 for low.
- R4: After a 1 is sampled, the next low starts a new slot at once. After a 0 is sampled, the block ignores the line until it has gone high, so a long low gives only one bit.
- R5: When the line rises after a low that lasted more than NRM_RST_CYC counted cycles, a reset strobe is issued with the overdrive flag at 0. This applies in either mode and takes priority over the short reset.
- R6: When overdrive mode is active and the low lasted more than OVD_RST_CYC but not more than NRM_RST_CYC, a reset strobe is issued with the overdrive flag at 1. In normal mode the same low is not a reset. The mode input takes effect one cycle after it is sampled.
- R7: A low no longer than the reset threshold in force ends an ordinary slot. It produces no reset strobe, and the block returns to waiting for a falling edge.
- R8: After a reset, the line is sampled once, when the count since the rise was detected equals NRM_PRES_CYC (normal) or OVD_PRES_CYC (overdrive). A low level gives the presence strobe with the present flag at 1. A high level gives it with the flag at 0.
- R9: After a presence sample with the present flag at 1, the block waits for the line to rise, and a presence pulse shorter than the reset threshold causes no reset. After a sample with the flag at 0, the block goes straight back to waiting for a fall.
- R10: The interval counter saturates at its all-ones value and never wraps back to zero, so a line held low for any length of time is still reported as a reset.
- R11: At most one of the bit, reset and presence strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | 1 | Asynchronous level of the monitored bus line |
| ovd_mode | input | 1 | High selects the short timing set (from a higher layer) |
| bit_stb | output | 1 | One-cycle strobe: a slot bit was sampled |
| bit_val | output | 1 | Sampled bit value, valid with bit_stb |
| rst_stb | output | 1 | One-cycle strobe: a reset pulse ended |
| rst_ovd | output | 1 | Reset qualified only by the short threshold, valid with rst_stb |
| pres_stb | output | 1 | One-cycle strobe: presence was sampled after a reset |
| pres_dev | output | 1 | A device answered (line low), valid with pres_stb |

## Verification
Every cycle, the assertions check several things: strobes never coincide; a bit value or presence flag matches the synchronized level seen in the cycle of the decision; a reset strobe follows only a high synchronized line; an overdrive reset flag appears only when the mode was requested two cycles earlier; and the interval counter never wraps. Some things only the bench scenarios can show. These are the exact sample instants under both timing sets, the end-to-end synchronizer latency, and the split between short lows, overdrive resets and normal resets, including the priority of the normal threshold in overdrive mode. The same holds for presence handling with and without a responder, and for a low held past counter saturation.

// File: rtl/owm_pkg.sv
package owm_pkg;

   typedef enum logic [1:0] {
      OWM_IDLE     = 2'd0,
      OWM_SAMPLE   = 2'd1,
      OWM_RISE     = 2'd2,
      OWM_PRESENCE = 2'd3
   } owm_state_e;

   typedef struct packed {
      logic bit_stb;
      logic bit_val;
      logic rst_stb;
      logic rst_ovd;
      logic pres_stb;
      logic pres_dev;
   } owm_evt_t;

   function automatic int owm_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("owm_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din};
      end
   end

   assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/owm_timer.sv
module owm_timer #(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= CNT_ONE;
      end else if (cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + CNT_ONE;
      end
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/owm_ctrl.sv
module owm_ctrl
   import owm_pkg::*;
#(
   parameter int CNT_W        = 14,
   parameter int NRM_BIT_CYC  = 150,
   parameter int NRM_PRES_CYC = 750,
   parameter int NRM_RST_CYC  = 4800,
   parameter int OVD_BIT_CYC  = 20,
   parameter int OVD_PRES_CYC = 100,
   parameter int OVD_RST_CYC  = 480
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             line_s,
   input  logic             mode_q,
   input  logic [CNT_W-1:0] cnt,
   output logic             clr,
   output owm_evt_t         evt
);

   localparam logic [CNT_W-1:0] NB_C = CNT_W'(NRM_BIT_CYC);
   localparam logic [CNT_W-1:0] NP_C = CNT_W'(NRM_PRES_CYC);
   localparam logic [CNT_W-1:0] NR_C = CNT_W'(NRM_RST_CYC);
   localparam logic [CNT_W-1:0] OB_C = CNT_W'(OVD_BIT_CYC);
   localparam logic [CNT_W-1:0] OP_C = CNT_W'(OVD_PRES_CYC);
   localparam logic [CNT_W-1:0] OR_C = CNT_W'(OVD_RST_CYC);

   owm_state_e       state_q, state_d;
   owm_evt_t         evt_q, evt_d;
   logic [CNT_W-1:0] bit_thr, pres_thr;
   logic             long_low, short_low;

   assign bit_thr   = mode_q ? OB_C : NB_C;
   assign pres_thr  = mode_q ? OP_C : NP_C;
   assign long_low  = (cnt > NR_C);
   assign short_low = mode_q && (cnt > OR_C);

   always_comb begin
      state_d = state_q;
      clr     = 1'b0;
      evt_d   = '0;
      unique case (state_q)
         OWM_IDLE: begin
            if (!line_s) begin
               clr     = 1'b1;
               state_d = OWM_SAMPLE;
            end
         end
         OWM_SAMPLE: begin
            if (cnt == bit_thr) begin
               evt_d.bit_stb = 1'b1;
               evt_d.bit_val = line_s;
               state_d       = line_s ? OWM_IDLE : OWM_RISE;
            end
         end
         OWM_RISE: begin
            if (line_s) begin
               if (long_low) begin
                  evt_d.rst_stb = 1'b1;
                  clr           = 1'b1;
                  state_d       = OWM_PRESENCE;
               end else if (short_low) begin
                  evt_d.rst_stb = 1'b1;
                  evt_d.rst_ovd = 1'b1;
                  clr           = 1'b1;
                  state_d       = OWM_PRESENCE;
               end else begin
                  state_d = OWM_IDLE;
               end
            end
         end
         OWM_PRESENCE: begin
            if (cnt == pres_thr) begin
               evt_d.pres_stb = 1'b1;
               evt_d.pres_dev = !line_s;
               if (!line_s) begin
                  clr     = 1'b1;
                  state_d = OWM_RISE;
               end else begin
                  state_d = OWM_IDLE;
               end
            end
         end
         default: state_d = OWM_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= OWM_IDLE;
         evt_q   <= '0;
      end else begin
         state_q <= state_d;
         evt_q   <= evt_d;
      end
   end

   assign evt = evt_q;

endmodule

// File: rtl/owire_link_monitor.sv
module owire_link_monitor
   import owm_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int CNT_W        = 14,
   parameter bit OVD_EN       = 1'b1,
   parameter int NRM_BIT_CYC  = 150,
   parameter int NRM_PRES_CYC = 750,
   parameter int NRM_RST_CYC  = 4800,
   parameter int OVD_BIT_CYC  = 20,
   parameter int OVD_PRES_CYC = 100,
   parameter int OVD_RST_CYC  = 480
) (
   input  logic clk,
   input  logic rst,
   input  logic line_in,
   input  logic ovd_mode,
   output logic bit_stb,
   output logic bit_val,
   output logic rst_stb,
   output logic rst_ovd,
   output logic pres_stb,
   output logic pres_dev
);

   localparam int MAX_THR = owm_max(owm_max(NRM_RST_CYC, NRM_PRES_CYC),
                                    owm_max(OVD_RST_CYC, OVD_PRES_CYC));

   if (MAX_THR + 1 >= (2 ** CNT_W)) begin : g_bad_width
      $error("owire_link_monitor: CNT_W too small for the thresholds");
   end
   if (NRM_BIT_CYC < 1 || OVD_BIT_CYC < 1 || NRM_PRES_CYC < 1 || OVD_PRES_CYC < 1) begin : g_bad_sample
      $error("owire_link_monitor: sample points must be at least one cycle");
   end
   if (OVD_RST_CYC >= NRM_RST_CYC || OVD_BIT_CYC > NRM_BIT_CYC) begin : g_bad_order
      $error("owire_link_monitor: overdrive timing must be shorter than normal timing");
   end
   if (NRM_BIT_CYC >= NRM_RST_CYC) begin : g_bad_bit
      $error("owire_link_monitor: bit sample must fall before the reset threshold");
   end

   logic             line_s;
   logic             mode_q;
   logic             clr;
   logic [CNT_W-1:0] cnt_q;
   owm_evt_t         evt;

   owm_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) i_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (line_in),
      .dout (line_s)
   );

   if (OVD_EN) begin : g_ovd
      logic mode_r;
      always_ff @(posedge clk) begin
         if (rst) mode_r <= 1'b0;
         else     mode_r <= ovd_mode;
      end
      assign mode_q = mode_r;
   end else begin : g_nrm_only
      assign mode_q = 1'b0;
   end

   owm_timer #(
      .CNT_W (CNT_W)
   ) i_timer (
      .clk (clk),
      .rst (rst),
      .clr (clr),
      .cnt (cnt_q)
   );

   owm_ctrl #(
      .CNT_W        (CNT_W),
      .NRM_BIT_CYC  (NRM_BIT_CYC),
      .NRM_PRES_CYC (NRM_PRES_CYC),
      .NRM_RST_CYC  (NRM_RST_CYC),
      .OVD_BIT_CYC  (OVD_BIT_CYC),
      .OVD_PRES_CYC (OVD_PRES_CYC),
      .OVD_RST_CYC  (OVD_RST_CYC)
   ) i_ctrl (
      .clk    (clk),
      .rst    (rst),
      .line_s (line_s),
      .mode_q (mode_q),
      .cnt    (cnt_q),
      .clr    (clr),
      .evt    (evt)
   );

   assign bit_stb  = evt.bit_stb;
   assign bit_val  = evt.bit_val;
   assign rst_stb  = evt.rst_stb;
   assign rst_ovd  = evt.rst_ovd;
   assign pres_stb = evt.pres_stb;
   assign pres_dev = evt.pres_dev;

endmodule

// File: rtl/owm_checker.sv
module owm_checker #(
   parameter int CNT_W = 14
) (
   input logic             clk,
   input logic             rst,
   input logic             ovd_mode,
   input logic             line_s,
   input logic [CNT_W-1:0] cnt,
   input logic             bit_stb,
   input logic             bit_val,
   input logic             rst_stb,
   input logic             rst_ovd,
   input logic             pres_stb,
   input logic             pres_dev
);

   AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst) $onehot0({bit_stb, rst_stb, pres_stb})); // R11
   AST_BIT_LEVEL: assert property (@(posedge clk) disable iff (rst) bit_stb |-> (bit_val == $past(line_s))); // R3
   AST_RST_ON_HIGH: assert property (@(posedge clk) disable iff (rst) rst_stb |-> $past(line_s)); // R5
   AST_OVD_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst) (rst_stb && rst_ovd) |-> $past(ovd_mode, 2)); // R6
   AST_PRES_LEVEL: assert property (@(posedge clk) disable iff (rst) pres_stb |-> (pres_dev == !$past(line_s))); // R8
   AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst) (cnt != '0) |=> (cnt != '0)); // R10

endmodule

bind owire_link_monitor owm_checker #(.CNT_W(CNT_W)) i_owm_checker (
   .clk      (clk),
   .rst      (rst),
   .ovd_mode (ovd_mode),
   .line_s   (line_s),
   .cnt      (cnt_q),
   .bit_stb  (bit_stb),
   .bit_val  (bit_val),
   .rst_stb  (rst_stb),
   .rst_ovd  (rst_ovd),
   .pres_stb (pres_stb),
   .pres_dev (pres_dev)
);

// File: tb/test_owire_link_monitor.sv
module test_owire_link_monitor;

   localparam int NB = 6, NP = 20, NR = 60, OB = 3, OP = 8, OR_T = 24;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic line_in = 1'b1;
   logic ovd_mode = 1'b0;
   logic bit_stb, bit_val, rst_stb, rst_ovd, pres_stb, pres_dev;

   always #2.5 clk = ~clk;

   owire_link_monitor #(
      .SYNC_STAGES (2), .CNT_W (7), .OVD_EN (1'b1),
      .NRM_BIT_CYC (NB), .NRM_PRES_CYC (NP), .NRM_RST_CYC (NR),
      .OVD_BIT_CYC (OB), .OVD_PRES_CYC (OP), .OVD_RST_CYC (OR_T)
   ) i_owire_link_monitor (
      .clk (clk), .rst (rst), .line_in (line_in), .ovd_mode (ovd_mode),
      .bit_stb (bit_stb), .bit_val (bit_val), .rst_stb (rst_stb),
      .rst_ovd (rst_ovd), .pres_stb (pres_stb), .pres_dev (pres_dev)
   );

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   // behavioural reference: delay queue for the synchronizer, elapsed counter, phase
   bit sq[$];
   int ph = 0;          // 0 wait fall, 1 wait sample, 2 wait high, 3 wait presence
   int el = 0;
   bit m_mode = 1'b0;
   bit m_bs, m_bv, m_rs, m_ro, m_ps, m_pd;

   always @(posedge clk) begin
      if (rst) begin
         sq = '{1'b1, 1'b1};
         ph = 0; el = 0; m_mode = 1'b0;
         {m_bs, m_bv, m_rs, m_ro, m_ps, m_pd} = '0;
      end else begin
         bit lv;
         bit restart;
         lv = sq[1];
         restart = 1'b0;
         {m_bs, m_bv, m_rs, m_ro, m_ps, m_pd} = '0;
         if (ph == 0) begin
            if (!lv) begin restart = 1'b1; ph = 1; end
         end else if (ph == 1) begin
            if (el == (m_mode ? OB : NB)) begin
               m_bs = 1'b1; m_bv = lv; ph = lv ? 0 : 2;
            end
         end else if (ph == 2) begin
            if (lv) begin
               if (el > NR) begin m_rs = 1'b1; restart = 1'b1; ph = 3; end
               else if (m_mode && el > OR_T) begin m_rs = 1'b1; m_ro = 1'b1; restart = 1'b1; ph = 3; end
               else ph = 0;
            end
         end else begin
            if (el == (m_mode ? OP : NP)) begin
               m_ps = 1'b1; m_pd = !lv;
               if (!lv) begin restart = 1'b1; ph = 2; end else ph = 0;
            end
         end
         el = restart ? 1 : el + 1;
         m_mode = ovd_mode;
         sq.push_front(line_in);
         void'(sq.pop_back());
      end
   end

   // event tallies seen at the ports
   int c_bit = 0, c_bit1 = 0, c_rst = 0, c_rovd = 0, c_pres = 0, c_dev = 0, c_coinc = 0;

   always @(negedge clk) begin
      if (!rst) begin
         n_cmp++;
         if ({bit_stb, bit_stb & bit_val} !== {m_bs, m_bs & m_bv}) begin
            n_bad++;
            $display("FAIL R3 bit event: got %b/%b expected %b/%b", bit_stb, bit_val, m_bs, m_bv);
         end
         if ({rst_stb, rst_stb & rst_ovd} !== {m_rs, m_rs & m_ro}) begin
            n_bad++;
            $display("FAIL R5 R6 reset event: got %b/%b expected %b/%b", rst_stb, rst_ovd, m_rs, m_ro);
         end
         if ({pres_stb, pres_stb & pres_dev} !== {m_ps, m_ps & m_pd}) begin
            n_bad++;
            $display("FAIL R8 presence event: got %b/%b expected %b/%b", pres_stb, pres_dev, m_ps, m_pd);
         end
         if (bit_stb) begin c_bit++; if (bit_val) c_bit1++; end
         if (rst_stb) begin c_rst++; if (rst_ovd) c_rovd++; end
         if (pres_stb) begin c_pres++; if (pres_dev) c_dev++; end
         if (int'(bit_stb) + int'(rst_stb) + int'(pres_stb) > 1) c_coinc++;
      end
   end

   task automatic chk(input string tag, input int got, input int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic clear_tallies();
      c_bit = 0; c_bit1 = 0; c_rst = 0; c_rovd = 0; c_pres = 0; c_dev = 0;
   endtask

   task automatic drive(input bit lvl, input int cycles);
      line_in = lvl;
      repeat (cycles) @(negedge clk);
   endtask

   task automatic expect_tallies(input string tag, input int b, input int b1, input int r,
                                 input int ro, input int p, input int pd);
      repeat (4) @(negedge clk);
      chk({tag, " bits"}, c_bit, b);
      chk({tag, " ones"}, c_bit1, b1);
      chk({tag, " resets"}, c_rst, r);
      chk({tag, " short resets"}, c_rovd, ro);
      chk({tag, " presence"}, c_pres, p);
      chk({tag, " devices"}, c_dev, pd);
      clear_tallies();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int lat;
      repeat (5) @(negedge clk);
      // R1: outputs quiet while in reset
      chk("R1 strobes in reset", int'({bit_stb, rst_stb, pres_stb}), 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 strobes after reset", int'({bit_stb, rst_stb, pres_stb}), 0);
      repeat (5) @(negedge clk);
      clear_tallies();

      // R2: latency from a driven low to the bit strobe
      line_in = 1'b0;
      lat = 0;
      @(negedge clk); lat++;
      line_in = 1'b1;
      @(negedge clk); lat++;
      while (!bit_stb && lat < 40) begin @(negedge clk); lat++; end
      chk("R2 low-to-bit latency", lat, 2 + NB + 1);
      drive(1'b1, 20);
      expect_tallies("R3 write one", 1, 1, 0, 0, 0, 0);

      drive(1'b0, 20); drive(1'b1, 30);
      expect_tallies("R3 write zero", 1, 0, 0, 0, 0, 0);

      // R4: back-to-back ones each start a fresh slot; a long low gives only one bit
      drive(1'b0, 2); drive(1'b1, 8); drive(1'b0, 2); drive(1'b1, 20);
      expect_tallies("R4 two ones", 2, 2, 0, 0, 0, 0);
      drive(1'b0, 45); drive(1'b1, 30);
      expect_tallies("R4 single bit per long low", 1, 0, 0, 0, 0, 0);

      // R5 + R8 + R9: normal reset with a responding device
      drive(1'b0, 80); drive(1'b1, 4); drive(1'b0, 40); drive(1'b1, 60);
      expect_tallies("R5 R9 reset with device", 1, 0, 1, 0, 1, 1);

      // R8: normal reset, nobody answers
      drive(1'b0, 80); drive(1'b1, 60);
      expect_tallies("R8 reset without device", 1, 0, 1, 0, 1, 0);

      // R7: a low just under the normal threshold is no reset
      drive(1'b0, 55); drive(1'b1, 40);
      expect_tallies("R7 short low", 1, 0, 0, 0, 0, 0);

      // R6: switch to overdrive timing
      ovd_mode = 1'b1;
      repeat (4) @(negedge clk);
      drive(1'b0, 1); drive(1'b1, 12);
      expect_tallies("R3 overdrive one", 1, 1, 0, 0, 0, 0);
      drive(1'b0, 6); drive(1'b1, 12);
      expect_tallies("R3 overdrive zero", 1, 0, 0, 0, 0, 0);
      drive(1'b0, 30); drive(1'b1, 2); drive(1'b0, 12); drive(1'b1, 40);
      expect_tallies("R6 R9 overdrive reset with device", 1, 0, 1, 1, 1, 1);
      drive(1'b0, 80); drive(1'b1, 40);
      expect_tallies("R5 normal reset wins in overdrive", 1, 0, 1, 0, 1, 0);

      // R6: same short reset low in normal mode is ignored
      ovd_mode = 1'b0;
      repeat (4) @(negedge clk);
      drive(1'b0, 30); drive(1'b1, 40);
      expect_tallies("R6 R7 normal mode ignores short reset", 1, 0, 0, 0, 0, 0);

      // R10: low held well past counter saturation (127)
      drive(1'b0, 300); drive(1'b1, 60);
      expect_tallies("R10 saturated low", 1, 0, 1, 0, 1, 0);

      chk("R11 coincident strobes", c_coinc, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule